// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block sits between a set of internal digital peripherals and a small general-purpose port of up to eight pins. Software picks which peripheral functions are enabled and which pins are digital or analog. A priority decoder then packs the enabled functions onto the digital pins. It walks the pins upward from pin 0, skips the analog ones, and places the functions from the highest priority down. Any digital pin that no function claims is driven from the port output latch.

Each pin can drive either push-pull or open-drain. One global bit turns off every weak pull-up. A master enable sets whether any drive reaches the pads at all. The inputs sampled at the pads are routed back to whichever function owns each pin. A function that found no pin sees a fixed idle level. If the enabled functions need more pins than there are digital pins, the lowest-priority functions are dropped and a status output rises.

Top module: `pin_route_xbar`

## Requirements
- R1: After reset the master enable is off, every pin is digital (`pad_ana`=0) and open-drain (push-pull mask 0), `pad_oe` is 0, `pad_pu` is all ones, `map_overflow` is 0 and every `periph_in` bit is at the idle level 1.
- R2: Function slots have fixed priority indices, highest first: 0 SMBus data, 1 SMBus clock, 2 UART TX, 3 UART RX, 4 comparator out, 5 system clock out, 6 to 6+NUM_PCA-1 PCA channels, then timer 0, then timer 1. The k-th enabled slot in this order owns the k-th digital pin counted upward from pin 0.
- R3: A pin whose digital-mask bit is 0 is analog. It has `pad_ana`=1, `pad_oe`=0 and `pad_pu`=0, and no slot is assigned to it.
- R4: A digital pin that no slot claims takes its level from `gpio_latch` at the same bit position, and the latch always asks to drive.
- R5: In push-pull mode a driving source gives `pad_oe`=1 with `pad_drv` equal to its level. In open-drain mode a level of 0 gives `pad_oe`=1 and `pad_drv`=0, and a level of 1 gives `pad_oe`=0. `pad_drv` is meaningful only while `pad_oe` is 1.
- R6: While the master enable is 0, `pad_oe` is 0 on every pin and every `periph_in` bit is 1.
- R7: `pad_pu` is 1 exactly when the pin is digital, the global pull-up disable is 0, and the pin is not being driven low.
- R8: When more slots are enabled than there are digital pins, `map_overflow` is 1. The surplus lowest-priority slots get no pin, and their `periph_in` is 1.
- R9: With the master enable on, a mapped slot's `periph_in` equals `pad_in` of the pin it owns.
- R10: The input-only slots (UART RX, timer 0, timer 1) never enable a pad driver, whatever their `periph_oe` says.
- R11: The PCA count field enables channels 0 up to count-1. A count above NUM_PCA enables all NUM_PCA channels.
- R12: A write is taken at the rising clock edge when `wr_en` is 1. Address 0 holds: bit0 SMBus, bit1 UART, bit2 comparator, bit3 system clock, bits 6:4 PCA count. Address 1 holds: bit0 timer 0, bit1 timer 1, bit6 pull-up disable, bit7 master enable. Address 2 is the digital mask (1 = digital). Address 3 is the push-pull mask (1 = push-pull). The new setting shows on the outputs from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write value |
| gpio_latch | input | NUM_PINS | Port output latch levels |
| periph_out | input | NUM_SLOTS | Output level per function slot |
| periph_oe | input | NUM_SLOTS | Drive request per function slot |
| periph_in | output | NUM_SLOTS | Pad level routed to each function slot |
| pad_in | input | NUM_PINS | Level sampled at each pad |
| pad_drv | output | NUM_PINS | Level to drive on each pad |
| pad_oe | output | NUM_PINS | Pad driver enable |
| pad_pu | output | NUM_PINS | Weak pull-up enable |
| pad_ana | output | NUM_PINS | Analog mode select |
| map_overflow | output | 1 | Enabled slots exceed digital pins |

## Verification
The bench builds the block with eight pins and four PCA channels, which gives twelve slots against eight pins. With these values an all-digital port can still be overrun, so the overflow path and the dropping of the lowest-priority slots can be reached. Writing a PCA count of 7 exercises the clamp. A behavioural model allocates pins from a queue of the enabled slots and is compared on every clock, both during directed scenarios and during a long run of random configurations, pad levels and peripheral requests.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

   localparam int SLOT_SDA    = 0;
   localparam int SLOT_SCL    = 1;
   localparam int SLOT_TX     = 2;
   localparam int SLOT_RX     = 3;
   localparam int SLOT_CMP    = 4;
   localparam int SLOT_CLK    = 5;
   localparam int SLOT_PCA0   = 6;
   // slots that are not PCA channels: six ahead of them, two timers after
   localparam int FIXED_SLOTS = 8;

   typedef enum logic [1:0] {
      ADDR_CTRL_A = 2'd0,
      ADDR_CTRL_B = 2'd1,
      ADDR_DIG    = 2'd2,
      ADDR_PP     = 2'd3
   } addr_e;

   typedef struct packed {
      logic       smb;
      logic       uart;
      logic       cmp;
      logic       clk;
      logic [2:0] pca_cnt;
      logic       t0;
      logic       t1;
      logic       pu_dis;
      logic       glob;
   } cfg_t;

endpackage

// File: rtl/pxb_regs.sv
module pxb_regs
   import pxb_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_addr,
   input  logic [7:0]          wr_data,
   output cfg_t                cfg,
   output logic [NUM_PINS-1:0] dig_mask,
   output logic [NUM_PINS-1:0] pp_mask
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '0;
         dig_mask <= '1;
         pp_mask  <= '0;
      end else if (wr_en) begin
         case (addr_e'(wr_addr))
            ADDR_CTRL_A: begin
               cfg.smb     <= wr_data[0];
               cfg.uart    <= wr_data[1];
               cfg.cmp     <= wr_data[2];
               cfg.clk     <= wr_data[3];
               cfg.pca_cnt <= wr_data[6:4];
            end
            ADDR_CTRL_B: begin
               cfg.t0     <= wr_data[0];
               cfg.t1     <= wr_data[1];
               cfg.pu_dis <= wr_data[6];
               cfg.glob   <= wr_data[7];
            end
            ADDR_DIG: dig_mask <= wr_data[NUM_PINS-1:0];
            ADDR_PP:  pp_mask  <= wr_data[NUM_PINS-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pxb_alloc.sv
module pxb_alloc #(
   parameter int NUM_SLOTS = 12,
   parameter int NUM_PINS  = 8,
   localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int PW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int MAXN = (NUM_SLOTS > NUM_PINS) ? NUM_SLOTS : NUM_PINS,
   localparam int CW = $clog2(MAXN + 1)
) (
   input  logic [NUM_SLOTS-1:0]          slot_en,
   input  logic [NUM_PINS-1:0]           dig_mask,
   output logic [NUM_PINS-1:0]           pin_hit,
   output logic [NUM_PINS-1:0][SW-1:0]   pin_slot,
   output logic [NUM_SLOTS-1:0]          slot_hit,
   output logic [NUM_SLOTS-1:0][PW-1:0]  slot_pin,
   output logic                          overflow
);

   // rank of a slot = enabled slots ahead of it; rank of a pin = digital pins below it
   logic [NUM_SLOTS-1:0][CW-1:0] srank;
   logic [NUM_PINS-1:0][CW-1:0]  prank;
   logic [CW-1:0]                slot_total;
   logic [CW-1:0]                pin_total;

   always_comb begin
      srank[0] = '0;
      for (int s = 1; s < NUM_SLOTS; s++)
         srank[s] = srank[s-1] + CW'(slot_en[s-1]);
      prank[0] = '0;
      for (int p = 1; p < NUM_PINS; p++)
         prank[p] = prank[p-1] + CW'(dig_mask[p-1]);
      slot_total = srank[NUM_SLOTS-1] + CW'(slot_en[NUM_SLOTS-1]);
      pin_total  = prank[NUM_PINS-1] + CW'(dig_mask[NUM_PINS-1]);
   end

   always_comb begin
      pin_hit  = '0;
      pin_slot = '0;
      slot_hit = '0;
      slot_pin = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (slot_en[s] && dig_mask[p] && (srank[s] == prank[p])) begin
               pin_hit[p]  = 1'b1;
               pin_slot[p] = SW'(s);
               slot_hit[s] = 1'b1;
               slot_pin[s] = PW'(p);
            end
         end
      end
   end

   assign overflow = (slot_total > pin_total);

endmodule

// File: rtl/pxb_pad.sv
module pxb_pad (
   input  logic glob,
   input  logic dig,
   input  logic pp,
   input  logic pu_dis,
   input  logic hit,
   input  logic src_val,
   input  logic src_oe,
   input  logic latch,
   output logic drv,
   output logic oe,
   output logic pu,
   output logic ana
);

   logic want_val;
   logic want_oe;
   logic active;

   assign want_val = hit ? src_val : latch;
   assign want_oe  = hit ? src_oe : 1'b1;
   assign active   = glob & dig;

   assign oe  = active & want_oe & (pp | ~want_val);
   assign drv = active & pp & want_val;
   assign pu  = dig & ~pu_dis & ~(oe & ~drv);
   assign ana = ~dig;

endmodule

// File: rtl/pin_route_xbar.sv
module pin_route_xbar
   import pxb_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int NUM_PCA     = 4,
   parameter bit UNMAPPED_IN = 1'b1,
   localparam int NUM_SLOTS  = FIXED_SLOTS + NUM_PCA
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [7:0]           wr_data,
   input  logic [NUM_PINS-1:0]  gpio_latch,
   input  logic [NUM_SLOTS-1:0] periph_out,
   input  logic [NUM_SLOTS-1:0] periph_oe,
   output logic [NUM_SLOTS-1:0] periph_in,
   input  logic [NUM_PINS-1:0]  pad_in,
   output logic [NUM_PINS-1:0]  pad_drv,
   output logic [NUM_PINS-1:0]  pad_oe,
   output logic [NUM_PINS-1:0]  pad_pu,
   output logic [NUM_PINS-1:0]  pad_ana,
   output logic                 map_overflow
);

   localparam int SW      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
   localparam int PW      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam int SLOT_T0 = SLOT_PCA0 + NUM_PCA;
   localparam int SLOT_T1 = SLOT_T0 + 1;
   localparam logic [NUM_SLOTS-1:0] IN_ONLY =
      (NUM_SLOTS'(1) << SLOT_RX) | (NUM_SLOTS'(1) << SLOT_T0) | (NUM_SLOTS'(1) << SLOT_T1);

   if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
      $error("pin_route_xbar: NUM_PINS must lie in 1..8");
   end
   if (NUM_PCA < 1 || NUM_PCA > 7) begin : g_bad_pca
      $error("pin_route_xbar: NUM_PCA must lie in 1..7");
   end

   cfg_t                          cfg;
   logic [NUM_PINS-1:0]           dig_mask;
   logic [NUM_PINS-1:0]           pp_mask;
   logic [NUM_SLOTS-1:0]          slot_en;
   logic [NUM_SLOTS-1:0]          src_oe;
   logic [NUM_PINS-1:0]           pin_hit;
   logic [NUM_PINS-1:0][SW-1:0]   pin_slot;
   logic [NUM_SLOTS-1:0]          slot_hit;
   logic [NUM_SLOTS-1:0][PW-1:0]  slot_pin;

   pxb_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cfg      (cfg),
      .dig_mask (dig_mask),
      .pp_mask  (pp_mask)
   );

   // slot enables in priority order
   assign slot_en[SLOT_SDA] = cfg.smb;
   assign slot_en[SLOT_SCL] = cfg.smb;
   assign slot_en[SLOT_TX]  = cfg.uart;
   assign slot_en[SLOT_RX]  = cfg.uart;
   assign slot_en[SLOT_CMP] = cfg.cmp;
   assign slot_en[SLOT_CLK] = cfg.clk;
   for (genvar i = 0; i < NUM_PCA; i++) begin : g_pca
      assign slot_en[SLOT_PCA0+i] = (cfg.pca_cnt > 3'(i));
   end
   assign slot_en[SLOT_T0] = cfg.t0;
   assign slot_en[SLOT_T1] = cfg.t1;

   assign src_oe = periph_oe & ~IN_ONLY;

   pxb_alloc #(.NUM_SLOTS(NUM_SLOTS), .NUM_PINS(NUM_PINS)) u_alloc (
      .slot_en  (slot_en),
      .dig_mask (dig_mask),
      .pin_hit  (pin_hit),
      .pin_slot (pin_slot),
      .slot_hit (slot_hit),
      .slot_pin (slot_pin),
      .overflow (map_overflow)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pxb_pad u_pad (
         .glob    (cfg.glob),
         .dig     (dig_mask[p]),
         .pp      (pp_mask[p]),
         .pu_dis  (cfg.pu_dis),
         .hit     (pin_hit[p]),
         .src_val (periph_out[pin_slot[p]]),
         .src_oe  (src_oe[pin_slot[p]]),
         .latch   (gpio_latch[p]),
         .drv     (pad_drv[p]),
         .oe      (pad_oe[p]),
         .pu      (pad_pu[p]),
         .ana     (pad_ana[p])
      );
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_in
      assign periph_in[s] = (cfg.glob && slot_hit[s]) ? pad_in[slot_pin[s]] : UNMAPPED_IN;
   end

endmodule

// File: rtl/pxb_chk.sv
module pxb_chk
   import pxb_pkg::*;
#(
   parameter int NUM_PINS  = 8,
   parameter int NUM_SLOTS = 12,
   localparam int PW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [1:0]                    wr_addr,
   input logic [7:0]                    wr_data,
   input cfg_t                          cfg,
   input logic [NUM_PINS-1:0]           dig_mask,
   input logic [NUM_PINS-1:0]           pp_mask,
   input logic [NUM_PINS-1:0]           pin_hit,
   input logic [NUM_SLOTS-1:0]          slot_hit,
   input logic [NUM_SLOTS-1:0][PW-1:0]  slot_pin,
   input logic [NUM_PINS-1:0]           pad_drv,
   input logic [NUM_PINS-1:0]           pad_oe,
   input logic [NUM_PINS-1:0]           pad_pu,
   input logic [NUM_PINS-1:0]           pad_ana,
   input logic                          map_overflow
);

   assert_analog_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_ana & (pad_oe | pad_pu)) == '0);

   assert_xbar_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.glob |-> (pad_oe == '0));

   assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~pp_mask & pad_drv) == '0);

   assert_pullup_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.pu_dis |-> (pad_pu == '0));

   assert_full_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
      map_overflow |-> (pin_hit == dig_mask));

   assert_rx_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.glob && slot_hit[SLOT_RX]) |-> !pad_oe[slot_pin[SLOT_RX]]);

   assert_t0_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.glob && slot_hit[NUM_SLOTS-2]) |-> !pad_oe[slot_pin[NUM_SLOTS-2]]);

   assert_t1_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.glob && slot_hit[NUM_SLOTS-1]) |-> !pad_oe[slot_pin[NUM_SLOTS-1]]);

   assert_dig_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2) |=> (dig_mask == $past(wr_data[NUM_PINS-1:0])));

endmodule

bind pin_route_xbar pxb_chk #(.NUM_PINS(NUM_PINS), .NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .cfg          (cfg),
   .dig_mask     (dig_mask),
   .pp_mask      (pp_mask),
   .pin_hit      (pin_hit),
   .slot_hit     (slot_hit),
   .slot_pin     (slot_pin),
   .pad_drv      (pad_drv),
   .pad_oe       (pad_oe),
   .pad_pu       (pad_pu),
   .pad_ana      (pad_ana),
   .map_overflow (map_overflow)
);

// File: tb/tb_pin_route_xbar.sv
module tb_pin_route_xbar;

   localparam int CLK_PERIOD = 10;
   localparam int NP   = 8;
   localparam int NPCA = 4;
   localparam int NS   = 8 + NPCA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [NP-1:0] gpio_latch = '0;
   logic [NS-1:0] periph_out = '0;
   logic [NS-1:0] periph_oe = '0;
   logic [NS-1:0] periph_in;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_drv, pad_oe, pad_pu, pad_ana;
   logic          map_overflow;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_route_xbar #(.NUM_PINS(NP), .NUM_PCA(NPCA)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .gpio_latch(gpio_latch), .periph_out(periph_out), .periph_oe(periph_oe),
      .periph_in(periph_in), .pad_in(pad_in), .pad_drv(pad_drv), .pad_oe(pad_oe),
      .pad_pu(pad_pu), .pad_ana(pad_ana), .map_overflow(map_overflow)
   );

   // ---------------- reference model: register image ----------------
   bit m_smb, m_uart, m_cmp, m_clk, m_t0, m_t1, m_pud, m_glob;
   int m_pca;
   logic [NP-1:0] m_dig, m_pp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_smb = 0; m_uart = 0; m_cmp = 0; m_clk = 0; m_t0 = 0; m_t1 = 0;
         m_pud = 0; m_glob = 0; m_pca = 0; m_dig = '1; m_pp = '0;
      end else if (wr_en) begin
         case (wr_addr)
            2'd0: begin
               m_smb = wr_data[0]; m_uart = wr_data[1]; m_cmp = wr_data[2];
               m_clk = wr_data[3]; m_pca = int'(wr_data[6:4]);
            end
            2'd1: begin
               m_t0 = wr_data[0]; m_t1 = wr_data[1]; m_pud = wr_data[6]; m_glob = wr_data[7];
            end
            2'd2: m_dig = wr_data[NP-1:0];
            default: m_pp = wr_data[NP-1:0];
         endcase
      end
   end

   function automatic bit m_slot_on(int s);
      if (s < 2)         return m_smb;
      if (s < 4)         return m_uart;
      if (s == 4)        return m_cmp;
      if (s == 5)        return m_clk;
      if (s < 6 + NPCA)  return (s - 6) < m_pca;
      if (s == 6 + NPCA) return m_t0;
      return m_t1;
   endfunction

   function automatic bit m_in_only(int s);
      return (s == 3) || (s == 6 + NPCA) || (s == 7 + NPCA);
   endfunction

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      int q[$];
      int pslot[NP];
      int spin[NS];
      logic [NP-1:0] e_ana, e_oe, e_drv, e_pu;
      logic [NS-1:0] e_in;
      bit e_ovf, v, e;
      if (!done) begin
         q.delete();
         for (int s = 0; s < NS; s++) begin
            spin[s] = -1;
            if (m_slot_on(s)) q.push_back(s);
         end
         for (int p = 0; p < NP; p++) begin
            pslot[p] = -1;
            if (m_dig[p] && q.size() > 0) begin
               pslot[p] = q.pop_front();
               spin[pslot[p]] = p;
            end
         end
         e_ovf = (q.size() > 0);
         for (int p = 0; p < NP; p++) begin
            e_ana[p] = !m_dig[p];
            e_oe[p] = 0; e_drv[p] = 0; e_pu[p] = 0;
            if (m_dig[p]) begin
               if (pslot[p] >= 0) begin
                  v = periph_out[pslot[p]];
                  e = periph_oe[pslot[p]] && !m_in_only(pslot[p]);
               end else begin
                  v = gpio_latch[p];
                  e = 1;
               end
               if (m_glob) begin
                  if (m_pp[p]) begin e_oe[p] = e; e_drv[p] = v; end
                  else begin e_oe[p] = e && !v; e_drv[p] = 0; end
               end
               e_pu[p] = !m_pud && !(e_oe[p] && !e_drv[p]);
            end
         end
         for (int s = 0; s < NS; s++)
            e_in[s] = (m_glob && spin[s] >= 0) ? pad_in[spin[s]] : 1'b1;

         checks += 5;
         if (pad_ana !== e_ana) begin
            failures++; $display("FAIL R3 pad_ana got %b exp %b t=%0t", pad_ana, e_ana, $time);
         end
         if (pad_oe !== e_oe) begin
            failures++; $display("FAIL R2 pad_oe got %b exp %b t=%0t", pad_oe, e_oe, $time);
         end
         if ((pad_drv & e_oe) !== (e_drv & e_oe)) begin
            failures++; $display("FAIL R5 pad_drv got %b exp %b t=%0t", pad_drv & e_oe, e_drv & e_oe, $time);
         end
         if (pad_pu !== e_pu) begin
            failures++; $display("FAIL R7 pad_pu got %b exp %b t=%0t", pad_pu, e_pu, $time);
         end
         if (periph_in !== e_in || map_overflow !== e_ovf) begin
            failures++;
            $display("FAIL R9/R8 periph_in,ovf got %b,%b exp %b,%b t=%0t",
                     periph_in, map_overflow, e_in, e_ovf, $time);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got %h exp %h t=%0t", req, got, exp, $time);
      end
   endtask

   // ---------------- directed and random scenarios ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 pad_oe",  pad_oe, 0);
      chk("R1 pad_ana", pad_ana, 0);
      chk("R1 pad_pu",  pad_pu, 8'hFF);
      chk("R1 ovf",     map_overflow, 0);
      chk("R1 periph_in", periph_in, {NS{1'b1}});
      @(posedge clk); #1 rst_n = 1;

      // R2/R4/R10: SMBus + UART on an all-digital push-pull port
      wr(2'd1, 8'h80);
      wr(2'd0, 8'h03);
      wr(2'd3, 8'hFF);
      periph_out = '1; periph_oe = '1; gpio_latch = 8'hA5;
      @(negedge clk);
      chk("R2 pad_oe placement", pad_oe, 8'hF7);
      chk("R10 rx pin quiet", pad_oe[3], 0);
      chk("R4 latch levels", pad_drv[7:4], 4'hA);
      chk("R12 pp written", pad_drv[2:0], 3'b111);

      // R3/R9: pins 1 and 4 analog
      @(posedge clk); #1;
      wr(2'd2, 8'hED);
      pad_in = 8'hDF;
      @(negedge clk);
      chk("R3 analog pins", pad_ana, 8'h12);
      chk("R3 analog quiet", pad_oe & 8'h12, 0);
      chk("R9 routed inputs", periph_in[3:0], 4'b0111);

      // R5/R7: open drain
      wr(2'd3, 8'h00);
      periph_out[0] = 0; periph_out[1] = 1;
      @(negedge clk);
      chk("R5 od low drives", {pad_oe[0], pad_drv[0]}, 2'b10);
      chk("R5 od high releases", pad_oe[2], 0);
      chk("R5 od latch", {pad_oe[7], pad_oe[6]}, 2'b01);
      chk("R7 pu driven low", pad_pu[0], 0);
      chk("R7 pu released", pad_pu[2], 1);

      wr(2'd1, 8'hC0);
      @(negedge clk);
      chk("R7 global pu off", pad_pu, 0);

      // R8/R11: every function on, PCA count 7
      wr(2'd2, 8'hFF);
      wr(2'd0, 8'h7F);
      wr(2'd1, 8'h83);
      pad_in = 8'h00;
      @(negedge clk);
      chk("R8 overflow flag", map_overflow, 1);
      chk("R8 dropped slots idle", periph_in[11:8], 4'hF);
      chk("R8 mapped pca", periph_in[7:6], 2'b00);

      wr(2'd0, 8'h70);
      pad_in = 8'h30;
      @(negedge clk);
      chk("R11 pca clamp", periph_in[11:6], 6'b110000);
      chk("R11 no overflow", map_overflow, 0);
      chk("R10 timer pins quiet", pad_oe[5:4], 2'b00);

      // R6: master enable off
      wr(2'd1, 8'h03);
      @(negedge clk);
      chk("R6 no drive", pad_oe, 0);
      chk("R6 inputs idle", periph_in, {NS{1'b1}});

      // R12: digital mask write
      wr(2'd2, 8'h0F);
      @(negedge clk);
      chk("R12 mask write", pad_ana, 8'hF0);

      // random configurations, compared every clock by the model
      for (int i = 0; i < 3000; i++) begin
         @(posedge clk); #1;
         if ($urandom_range(0, 4) == 0) begin
            wr_en = 1; wr_addr = 2'($urandom); wr_data = 8'($urandom);
            if (wr_addr == 2'd1 && $urandom_range(0, 3) != 0) wr_data[7] = 1;
         end else begin
            wr_en = 0;
         end
         gpio_latch = NP'($urandom);
         periph_out = NS'($urandom);
         periph_oe  = NS'($urandom);
         pad_in     = NP'($urandom);
      end
      @(posedge clk); #1 wr_en = 0;
      repeat (2) @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule